// File: doc/BRIEF.md
# Software-Controlled Reset Line with Keyword Unlock

This block drives one reset output that software owns through a 16-bit control word on a small memory-mapped port. The line is not driven by a plain control bit. It goes active only when one exact 16-bit keyword (0xDEAD) is written to the control word. It goes inactive only when the all-zero word is written there. Any other value written to the control word leaves the line as it was, so a stray or corrupted store cannot pulse a reset into the logic downstream.

The port decodes a word address. Address 0 holds the control word, which software can read and write. Address 1 is a reserved word that reads as zero and ignores writes. Every other address in the decoded range behaves the same as the reserved word. Readback is combinational from the address and the registered line state. The output comes straight from a flop, so it changes on the clock edge that samples the accepted write.

Top module: `rstctl_keyed`

## Requirements
- R1: While `rst_n` is low and after it rises, `sw_rst_o` is 0 and address 0 reads 0x0000.
- R2: A write (`bus_wr`=1) of 0xDEAD to address 0 sets `sw_rst_o` to 1 on the next rising clock edge.
- R3: A write of 0x0000 to address 0 clears `sw_rst_o` to 0 on the next rising clock edge.
- R4: A write to address 0 of any value other than 0xDEAD or 0x0000 leaves `sw_rst_o` unchanged.
- R5: Reading address 0 returns 0xDEAD while `sw_rst_o` is 1 and 0x0000 while it is 0.
- R6: Address 1 always reads 0x0000, and writes to it leave `sw_rst_o` unchanged.
- R7: Addresses 2 and above read 0x0000, and writes to them leave `sw_rst_o` unchanged.
- R8: With `bus_wr`=0, no value on `bus_wdata` or `bus_addr` changes `sw_rst_o`, and an accepted write does not change the output before the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| sw_rst_o | output | 1 | Registered reset line, active high |

## Verification
The hardest case to reach is a write to address 0 whose value is almost the keyword. Uniform random 16-bit data would hit 0xDEAD about once in 65,536 writes, so the keyword guard would go untested. The stimulus therefore draws each write word from a weighted mix:
- the exact keyword;
- zero;
- the keyword with one random bit flipped;
- fully random words.

Single-bit neighbours of the keyword are written while the line is both set and clear, so the hold behaviour is observed in each state.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned ADDR_W    = 4;
    localparam logic [WORD_W-1:0] SET_KEY   = 16'hDEAD;
    localparam logic [WORD_W-1:0] CLEAR_KEY = 16'h0000;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd0;
    localparam logic [ADDR_W-1:0] RSVD_ADDR = 4'd1;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_SET   = 2'b01,
        CMD_CLEAR = 2'b10
    } key_cmd_e;

    typedef struct packed {
        logic line;
    } ctl_state_t;
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output logic          sel_ctrl,
    output logic          sel_rsvd
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] RSVD_A = AW'(RSVD_ADDR);

    always_comb begin
        sel_ctrl = (addr == CTRL_A);
        sel_rsvd = (addr == RSVD_A);
    end
endmodule

// File: rtl/rstctl_keymatch.sv
module rstctl_keymatch
    import rstctl_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter logic [DW-1:0] SET_W = DW'(SET_KEY),
    parameter logic [DW-1:0] CLR_W = DW'(CLEAR_KEY)
) (
    input  logic [DW-1:0] word,
    output key_cmd_e      cmd
);
    logic [DW-1:0] diff_set;
    logic [DW-1:0] diff_clr;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign diff_set[b] = word[b] ^ SET_W[b];
        assign diff_clr[b] = word[b] ^ CLR_W[b];
    end

    always_comb begin
        if (diff_set == '0)      cmd = CMD_SET;
        else if (diff_clr == '0) cmd = CMD_CLEAR;
        else                     cmd = CMD_NONE;
    end
endmodule

// File: rtl/rstctl_readback.sv
module rstctl_readback
    import rstctl_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter logic [DW-1:0] SET_W = DW'(SET_KEY),
    parameter logic [DW-1:0] CLR_W = DW'(CLEAR_KEY)
) (
    input  logic          sel_ctrl,
    input  logic          line,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (sel_ctrl) rdata = line ? SET_W : CLR_W;
    end
endmodule

// File: rtl/rstctl_keyed.sv
module rstctl_keyed
    import rstctl_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sw_rst_o
);
    logic       sel_ctrl;
    logic       sel_rsvd;
    key_cmd_e   cmd;
    ctl_state_t st_d;
    ctl_state_t st_q;

    rstctl_decode #(.AW(AW)) u_decode (
        .addr     (bus_addr),
        .sel_ctrl (sel_ctrl),
        .sel_rsvd (sel_rsvd)
    );

    rstctl_keymatch #(.DW(DW)) u_match (
        .word (bus_wdata),
        .cmd  (cmd)
    );

    rstctl_readback #(.DW(DW)) u_rdback (
        .sel_ctrl (sel_ctrl),
        .line     (st_q.line),
        .rdata    (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr && sel_ctrl && !sel_rsvd) begin
            unique case (cmd)
                CMD_SET:   st_d.line = 1'b1;
                CMD_CLEAR: st_d.line = 1'b0;
                default:   st_d.line = st_q.line;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_rst_o = st_q.line;
endmodule

// File: rtl/rstctl_keyed_chk.sv
module rstctl_keyed_chk
    import rstctl_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = WORD_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          sw_rst_o
);
    logic to_ctrl;
    assign to_ctrl = bus_wr && (bus_addr == AW'(CTRL_ADDR));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (sw_rst_o == 1'b0);
        end
    end

    // R2
    set_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_ctrl && bus_wdata == DW'(SET_KEY)) |=> sw_rst_o);

    // R3
    clear_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_ctrl && bus_wdata == DW'(CLEAR_KEY)) |=> !sw_rst_o);

    // R4
    other_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_ctrl && bus_wdata != DW'(SET_KEY) && bus_wdata != DW'(CLEAR_KEY))
        |=> $stable(sw_rst_o));

    // R5
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(CTRL_ADDR))
        |-> (bus_rdata == (sw_rst_o ? DW'(SET_KEY) : DW'(CLEAR_KEY))));

    // R6
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != AW'(CTRL_ADDR)) |-> (bus_rdata == '0));

    // R8
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_ctrl) |=> $stable(sw_rst_o));
endmodule

bind rstctl_keyed rstctl_keyed_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sw_rst_o  (sw_rst_o)
);

// File: tb/rstctl_keyed_bench.sv
module rstctl_keyed_bench;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam logic [15:0] KEY = 16'hDEAD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          sw_rst_o;

    int checks = 0;
    int errors = 0;
    logic model = 1'b0;

    always #10 clk = ~clk;

    rstctl_keyed u_rstctl_keyed (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sw_rst_o  (sw_rst_o)
    );

    function automatic logic next_line(logic cur, logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
        if (!wr || a != 0) return cur;
        if (d == KEY)      return 1'b1;
        if (d == 16'h0000) return 1'b0;
        return cur;
    endfunction

    function automatic logic [DW-1:0] read_exp(logic cur, logic [AW-1:0] a);
        if (a != 0) return 16'h0000;
        return cur ? KEY : 16'h0000;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
        if (!wr)           return "R8";
        if (a == 1)        return "R6";
        if (a > 1)         return "R7";
        if (d == KEY)      return "R2";
        if (d == 16'h0000) return "R3";
        return "R4";
    endfunction

    // one bus cycle: drive at negedge, check read data and pre-edge output,
    // then check the output after the sampling edge
    task automatic cycle(logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        check(a == 0 ? "R5" : (a == 1 ? "R6" : "R7"), 32'(bus_rdata), 32'(read_exp(model, a)));
        check("R8", 32'(sw_rst_o), 32'(model));
        @(posedge clk);
        #1;
        model = next_line(model, wr, a, d);
        check(req_of(wr, a, d), 32'(sw_rst_o), 32'(model));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", 32'(sw_rst_o), 0);
        check("R1", 32'(bus_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 32'(sw_rst_o), 0);
        check("R1", 32'(bus_rdata), 0);

        // directed corner cases
        cycle(1'b0, 4'd0, KEY);              // R8 keyword without strobe
        cycle(1'b1, 4'd1, KEY);              // R6 keyword to reserved word
        cycle(1'b1, 4'd15, KEY);             // R7 keyword to top address
        cycle(1'b1, 4'd0, KEY ^ 16'h0001);   // R4 near keyword
        cycle(1'b1, 4'd0, KEY);              // R2 set
        cycle(1'b1, 4'd0, 16'h0001);         // R4 while set
        cycle(1'b1, 4'd0, 16'hDEAC);         // R4 while set
        cycle(1'b0, 4'd0, 16'h0000);         // R8 zero without strobe
        cycle(1'b1, 4'd1, 16'h0000);         // R6 zero to reserved word
        cycle(1'b1, 4'd2, 16'h0000);         // R7 zero to address 2
        cycle(1'b1, 4'd0, KEY);              // R2 repeat set
        cycle(1'b1, 4'd0, 16'h0000);         // R3 clear
        cycle(1'b1, 4'd0, 16'h0000);         // R3 repeat clear

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic          w;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 3)      d = KEY;
            else if (sel < 5) d = 16'h0000;
            else if (sel < 8) d = KEY ^ (16'h1 << $urandom_range(0, 15));
            else              d = 16'($urandom);
            a = ($urandom_range(0, 3) != 0) ? 4'd0 : 4'($urandom_range(1, 15));
            w = ($urandom_range(0, 4) != 0);
            cycle(w, a, d);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule